// File: doc/BRIEF.md
# Multiported Vector Register File with Forwarding

This block holds the working vectors of a SIMD datapath: sixteen registers, each a row of 16-bit lanes whose count is a parameter. Several vector execution units reach it at once through fixed groups of ports. The arithmetic unit, the multiply-accumulate unit and the load/store unit each have their own read and write ports. The permutation unit and the scalar-exchange unit take turns on one shared group, and the block arbitrates that group every cycle.

Reads are combinational. A read that names a register being written in the same cycle returns the incoming data instead of the stored value. Any write can be flagged as forward-only. Its result then reaches readers through that forwarding path during its own cycle, and the storage row keeps its old value. This lets short-lived intermediates skip the array and save write energy. A build-time switch widens the shared group to two read and two write ports, for a permutation network that handles vector pairs.

Top module: `simd_vrf`

## Requirements
- R1: Asserting the active-low asynchronous reset clears all 16 registers to zero, and every read port then returns zero.
- R2: The read ports are numbered as follows: fixed reads 0 and 1 belong to the arithmetic unit, 2 to 4 to the multiply-accumulate unit, and 5 to the load/store unit. The fixed writes are numbered 0 for arithmetic, 1 for multiply-accumulate and 2 for load/store. Shared ports come after the fixed ones in write priority. Each fixed read port returns, in the same cycle, the register its own address selects.
- R3: An enabled write with its forward-only flag low updates its register at the rising clock edge. Reads see the new value from the next cycle on.
- R4: A read whose address matches an enabled write in the same cycle returns that write's data combinationally, whether or not the write is forward-only.
- R5: A forward-only write leaves its register's stored value unchanged.
- R6: When several enabled writes name one register in a cycle, the lowest-numbered port among them decides both the forwarded data and the stored result. If that port is forward-only, the register keeps its value. `wr_collide_o` is high in that cycle.
- R7: The shared group is granted to the permutation unit whenever it requests. The scalar-exchange unit gets it only when it requests and the permutation unit does not. At most one grant is high, and `share_conflict_o` is high exactly when both request.
- R8: Shared writes from a unit without the grant have no effect. Shared read ports follow the addresses of the granted unit, and follow the scalar-exchange addresses when there is no grant.
- R9: With `DOUBLE_PERM` set, the shared group has two read and two write ports, for 8 reads and 5 writes in total. Otherwise it has one of each, for 7 and 4. Every shared port obeys R3 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fix_raddr_i | input | 6x4 | Fixed read addresses |
| fix_rdata_o | output | 6xVW | Fixed read data |
| fix_we_i | input | 3 | Fixed write enables |
| fix_wbd_i | input | 3 | Fixed forward-only flags |
| fix_waddr_i | input | 3x4 | Fixed write addresses |
| fix_wdata_i | input | 3xVW | Fixed write data |
| perm_req_i | input | 1 | Permutation unit requests shared group |
| perm_raddr_i | input | SHx4 | Permutation read addresses |
| perm_we_i | input | SH | Permutation write enables |
| perm_wbd_i | input | SH | Permutation forward-only flags |
| perm_waddr_i | input | SHx4 | Permutation write addresses |
| perm_wdata_i | input | SHxVW | Permutation write data |
| sx_req_i | input | 1 | Scalar-exchange unit requests shared group |
| sx_raddr_i | input | SHx4 | Scalar-exchange read addresses |
| sx_we_i | input | SH | Scalar-exchange write enables |
| sx_wbd_i | input | SH | Scalar-exchange forward-only flags |
| sx_waddr_i | input | SHx4 | Scalar-exchange write addresses |
| sx_wdata_i | input | SHxVW | Scalar-exchange write data |
| sh_rdata_o | output | SHxVW | Shared read data |
| perm_gnt_o | output | 1 | Shared group granted to permutation unit |
| sx_gnt_o | output | 1 | Shared group granted to scalar-exchange unit |
| share_conflict_o | output | 1 | Both units requested this cycle |
| wr_collide_o | output | 1 | Two enabled writes named one register |

VW is LANES*16. SH is 2 when DOUBLE_PERM is set and 1 otherwise.

## Verification
The assertions assume that every control input is a known 0 or 1 on each clock edge once reset is released. They also assume that the write flags of a port matter only while its enable is high. The stimulus drives every input at the falling edge from defined values, and it never leaves an X on an address, even for idle ports. It concentrates write and read addresses in a narrow range so that forwarding, collisions and shared-group conflicts occur often without driving anything outside its legal encoding.

// File: rtl/simd_vrf_pkg.sv
package simd_vrf_pkg;
  localparam int unsigned NREG   = 16;
  localparam int unsigned AW     = 4;
  localparam int unsigned ELEM_W = 16;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_PERM = 2'd1,
    SH_SX   = 2'd2
  } sh_owner_e;
endpackage

// File: rtl/simd_vrf_share_arb.sv
module simd_vrf_share_arb
  import simd_vrf_pkg::*;
#(
  parameter int unsigned VW    = 64,
  parameter int unsigned SH_RD = 1,
  parameter int unsigned SH_WR = 1
) (
  input  logic                        perm_req_i,
  input  logic [SH_RD-1:0][AW-1:0]    perm_raddr_i,
  input  logic [SH_WR-1:0]            perm_we_i,
  input  logic [SH_WR-1:0]            perm_wbd_i,
  input  logic [SH_WR-1:0][AW-1:0]    perm_waddr_i,
  input  logic [SH_WR-1:0][VW-1:0]    perm_wdata_i,
  input  logic                        sx_req_i,
  input  logic [SH_RD-1:0][AW-1:0]    sx_raddr_i,
  input  logic [SH_WR-1:0]            sx_we_i,
  input  logic [SH_WR-1:0]            sx_wbd_i,
  input  logic [SH_WR-1:0][AW-1:0]    sx_waddr_i,
  input  logic [SH_WR-1:0][VW-1:0]    sx_wdata_i,
  output logic                        perm_gnt_o,
  output logic                        sx_gnt_o,
  output logic                        conflict_o,
  output logic [SH_RD-1:0][AW-1:0]    sh_raddr_o,
  output logic [SH_WR-1:0]            sh_we_o,
  output logic [SH_WR-1:0]            sh_wbd_o,
  output logic [SH_WR-1:0][AW-1:0]    sh_waddr_o,
  output logic [SH_WR-1:0][VW-1:0]    sh_wdata_o
);
  sh_owner_e owner;

  // permutation unit has fixed priority
  always_comb begin
    if (perm_req_i)    owner = SH_PERM;
    else if (sx_req_i) owner = SH_SX;
    else               owner = SH_NONE;
  end

  assign perm_gnt_o = (owner == SH_PERM);
  assign sx_gnt_o   = (owner == SH_SX);
  assign conflict_o = perm_req_i & sx_req_i;

  for (genvar i = 0; i < int'(SH_RD); i++) begin : g_rd
    assign sh_raddr_o[i] = (owner == SH_PERM) ? perm_raddr_i[i] : sx_raddr_i[i];
  end

  for (genvar i = 0; i < int'(SH_WR); i++) begin : g_wr
    always_comb begin
      unique case (owner)
        SH_PERM: begin
          sh_we_o[i]    = perm_we_i[i];
          sh_wbd_o[i]   = perm_wbd_i[i];
          sh_waddr_o[i] = perm_waddr_i[i];
          sh_wdata_o[i] = perm_wdata_i[i];
        end
        SH_SX: begin
          sh_we_o[i]    = sx_we_i[i];
          sh_wbd_o[i]   = sx_wbd_i[i];
          sh_waddr_o[i] = sx_waddr_i[i];
          sh_wdata_o[i] = sx_wdata_i[i];
        end
        default: begin
          sh_we_o[i]    = 1'b0;
          sh_wbd_o[i]   = 1'b0;
          sh_waddr_o[i] = '0;
          sh_wdata_o[i] = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/simd_vrf_wr_resolve.sv
module simd_vrf_wr_resolve
  import simd_vrf_pkg::*;
#(
  parameter int unsigned VW   = 64,
  parameter int unsigned N_WR = 4
) (
  input  logic [N_WR-1:0]           we_i,
  input  logic [N_WR-1:0]           wbd_i,
  input  logic [N_WR-1:0][AW-1:0]   waddr_i,
  input  logic [N_WR-1:0][VW-1:0]   wdata_i,
  output logic [NREG-1:0]           byp_hit_o,
  output logic [NREG-1:0][VW-1:0]   byp_data_o,
  output logic [NREG-1:0]           commit_o,
  output logic                      collide_o
);
  logic [NREG-1:0] reg_coll;

  for (genvar r = 0; r < int'(NREG); r++) begin : g_reg
    logic          hit;
    logic          keep;
    logic          coll;
    logic [VW-1:0] data;

    // ascending scan: first match is the lowest-numbered port
    always_comb begin
      hit  = 1'b0;
      keep = 1'b0;
      coll = 1'b0;
      data = '0;
      for (int p = 0; p < int'(N_WR); p++) begin
        if (we_i[p] && waddr_i[p] == AW'(r)) begin
          if (!hit) begin
            hit  = 1'b1;
            keep = wbd_i[p];
            data = wdata_i[p];
          end else begin
            coll = 1'b1;
          end
        end
      end
    end

    assign byp_hit_o[r]  = hit;
    assign byp_data_o[r] = data;
    assign commit_o[r]   = hit & ~keep;
    assign reg_coll[r]   = coll;
  end

  assign collide_o = |reg_coll;
endmodule

// File: rtl/simd_vrf_rd_port.sv
module simd_vrf_rd_port
  import simd_vrf_pkg::*;
#(
  parameter int unsigned VW = 64
) (
  input  logic [AW-1:0]             raddr_i,
  input  logic [NREG-1:0][VW-1:0]   mem_i,
  input  logic [NREG-1:0]           byp_hit_i,
  input  logic [NREG-1:0][VW-1:0]   byp_data_i,
  output logic [VW-1:0]             rdata_o
);
  assign rdata_o = byp_hit_i[raddr_i] ? byp_data_i[raddr_i] : mem_i[raddr_i];
endmodule

// File: rtl/simd_vrf.sv
module simd_vrf
  import simd_vrf_pkg::*;
#(
  parameter int unsigned LANES       = 4,
  parameter bit          DOUBLE_PERM = 1'b0,
  localparam int unsigned VW     = LANES * ELEM_W,
  localparam int unsigned FIX_RD = 6,
  localparam int unsigned FIX_WR = 3,
  localparam int unsigned SH_RD  = DOUBLE_PERM ? 2 : 1,
  localparam int unsigned SH_WR  = DOUBLE_PERM ? 2 : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [FIX_RD-1:0][AW-1:0]    fix_raddr_i,
  output logic [FIX_RD-1:0][VW-1:0]    fix_rdata_o,
  input  logic [FIX_WR-1:0]            fix_we_i,
  input  logic [FIX_WR-1:0]            fix_wbd_i,
  input  logic [FIX_WR-1:0][AW-1:0]    fix_waddr_i,
  input  logic [FIX_WR-1:0][VW-1:0]    fix_wdata_i,
  input  logic                         perm_req_i,
  input  logic [SH_RD-1:0][AW-1:0]     perm_raddr_i,
  input  logic [SH_WR-1:0]             perm_we_i,
  input  logic [SH_WR-1:0]             perm_wbd_i,
  input  logic [SH_WR-1:0][AW-1:0]     perm_waddr_i,
  input  logic [SH_WR-1:0][VW-1:0]     perm_wdata_i,
  input  logic                         sx_req_i,
  input  logic [SH_RD-1:0][AW-1:0]     sx_raddr_i,
  input  logic [SH_WR-1:0]             sx_we_i,
  input  logic [SH_WR-1:0]             sx_wbd_i,
  input  logic [SH_WR-1:0][AW-1:0]     sx_waddr_i,
  input  logic [SH_WR-1:0][VW-1:0]     sx_wdata_i,
  output logic [SH_RD-1:0][VW-1:0]     sh_rdata_o,
  output logic                         perm_gnt_o,
  output logic                         sx_gnt_o,
  output logic                         share_conflict_o,
  output logic                         wr_collide_o
);
  localparam int unsigned N_RD = FIX_RD + SH_RD;
  localparam int unsigned N_WR = FIX_WR + SH_WR;

  logic [SH_RD-1:0][AW-1:0]  sh_raddr;
  logic [SH_WR-1:0]          sh_we;
  logic [SH_WR-1:0]          sh_wbd;
  logic [SH_WR-1:0][AW-1:0]  sh_waddr;
  logic [SH_WR-1:0][VW-1:0]  sh_wdata;

  simd_vrf_share_arb #(.VW(VW), .SH_RD(SH_RD), .SH_WR(SH_WR)) u_arb (
    .perm_req_i   (perm_req_i),
    .perm_raddr_i (perm_raddr_i),
    .perm_we_i    (perm_we_i),
    .perm_wbd_i   (perm_wbd_i),
    .perm_waddr_i (perm_waddr_i),
    .perm_wdata_i (perm_wdata_i),
    .sx_req_i     (sx_req_i),
    .sx_raddr_i   (sx_raddr_i),
    .sx_we_i      (sx_we_i),
    .sx_wbd_i     (sx_wbd_i),
    .sx_waddr_i   (sx_waddr_i),
    .sx_wdata_i   (sx_wdata_i),
    .perm_gnt_o   (perm_gnt_o),
    .sx_gnt_o     (sx_gnt_o),
    .conflict_o   (share_conflict_o),
    .sh_raddr_o   (sh_raddr),
    .sh_we_o      (sh_we),
    .sh_wbd_o     (sh_wbd),
    .sh_waddr_o   (sh_waddr),
    .sh_wdata_o   (sh_wdata)
  );

  // shared ports sit above the fixed ones, so fixed ports win collisions
  logic [N_RD-1:0][AW-1:0] all_raddr;
  logic [N_RD-1:0][VW-1:0] all_rdata;
  logic [N_WR-1:0]         all_we;
  logic [N_WR-1:0]         all_wbd;
  logic [N_WR-1:0][AW-1:0] all_waddr;
  logic [N_WR-1:0][VW-1:0] all_wdata;

  assign all_raddr = {sh_raddr, fix_raddr_i};
  assign all_we    = {sh_we, fix_we_i};
  assign all_wbd   = {sh_wbd, fix_wbd_i};
  assign all_waddr = {sh_waddr, fix_waddr_i};
  assign all_wdata = {sh_wdata, fix_wdata_i};

  logic [NREG-1:0]         byp_hit;
  logic [NREG-1:0][VW-1:0] byp_data;
  logic [NREG-1:0]         commit;

  simd_vrf_wr_resolve #(.VW(VW), .N_WR(N_WR)) u_resolve (
    .we_i       (all_we),
    .wbd_i      (all_wbd),
    .waddr_i    (all_waddr),
    .wdata_i    (all_wdata),
    .byp_hit_o  (byp_hit),
    .byp_data_o (byp_data),
    .commit_o   (commit),
    .collide_o  (wr_collide_o)
  );

  logic [NREG-1:0][VW-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      for (int r = 0; r < int'(NREG); r++) begin
        if (commit[r]) mem_q[r] <= byp_data[r];
      end
    end
  end

  for (genvar i = 0; i < int'(N_RD); i++) begin : g_rp
    simd_vrf_rd_port #(.VW(VW)) u_rp (
      .raddr_i    (all_raddr[i]),
      .mem_i      (mem_q),
      .byp_hit_i  (byp_hit),
      .byp_data_i (byp_data),
      .rdata_o    (all_rdata[i])
    );
  end

  assign fix_rdata_o = all_rdata[FIX_RD-1:0];
  assign sh_rdata_o  = all_rdata[N_RD-1:FIX_RD];

  // port 0 outranks every other writer
  assert_store_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fix_we_i[0] && !fix_wbd_i[0]) |=> mem_q[$past(fix_waddr_i[0])] == $past(fix_wdata_i[0]));

  assert_wbd_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fix_we_i[0] && fix_wbd_i[0]) |=> mem_q[$past(fix_waddr_i[0])] == $past(mem_q[fix_waddr_i[0]]));

  assert_bypass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fix_we_i[0] && fix_raddr_i[5] == fix_waddr_i[0]) |-> fix_rdata_o[5] == fix_wdata_i[0]);

  assert_collide_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fix_we_i[0] && fix_we_i[1] && fix_waddr_i[0] == fix_waddr_i[1]) |-> wr_collide_o);

  assert_one_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({perm_gnt_o, sx_gnt_o}));

  assert_perm_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perm_req_i && sx_req_i) |-> (perm_gnt_o && !sx_gnt_o && share_conflict_o));

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (mem_q == '0));
endmodule

// File: tb/tb_simd_vrf.sv
module tb_simd_vrf;
  localparam int VW = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [5:0][3:0]  fix_raddr;
  logic [5:0][63:0] fix_rdata;
  logic [2:0]       fix_we, fix_wbd;
  logic [2:0][3:0]  fix_waddr;
  logic [2:0][63:0] fix_wdata;
  logic             perm_req, sx_req;
  logic [1:0][3:0]  perm_raddr, sx_raddr, perm_waddr, sx_waddr;
  logic [1:0]       perm_we, perm_wbd, sx_we, sx_wbd;
  logic [1:0][63:0] perm_wdata, sx_wdata, sh_rdata;
  logic             perm_gnt, sx_gnt, share_conflict, wr_collide;

  simd_vrf #(.LANES(4), .DOUBLE_PERM(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .fix_raddr_i(fix_raddr), .fix_rdata_o(fix_rdata),
    .fix_we_i(fix_we), .fix_wbd_i(fix_wbd), .fix_waddr_i(fix_waddr), .fix_wdata_i(fix_wdata),
    .perm_req_i(perm_req), .perm_raddr_i(perm_raddr), .perm_we_i(perm_we), .perm_wbd_i(perm_wbd),
    .perm_waddr_i(perm_waddr), .perm_wdata_i(perm_wdata),
    .sx_req_i(sx_req), .sx_raddr_i(sx_raddr), .sx_we_i(sx_we), .sx_wbd_i(sx_wbd),
    .sx_waddr_i(sx_waddr), .sx_wdata_i(sx_wdata),
    .sh_rdata_o(sh_rdata), .perm_gnt_o(perm_gnt), .sx_gnt_o(sx_gnt),
    .share_conflict_o(share_conflict), .wr_collide_o(wr_collide)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [63:0] ref_mem [16];
  logic        m_en   [5];
  logic        m_wbd  [5];
  logic [3:0]  m_addr [5];
  logic [63:0] m_data [5];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  // reference: build the prioritized write list from the port inputs
  task automatic build_writes();
    for (int p = 0; p < 3; p++) begin
      m_en[p] = fix_we[p]; m_wbd[p] = fix_wbd[p];
      m_addr[p] = fix_waddr[p]; m_data[p] = fix_wdata[p];
    end
    for (int k = 0; k < 2; k++) begin
      if (perm_req) begin
        m_en[3+k] = perm_we[k]; m_wbd[3+k] = perm_wbd[k];
        m_addr[3+k] = perm_waddr[k]; m_data[3+k] = perm_wdata[k];
      end else begin
        m_en[3+k] = sx_req && sx_we[k]; m_wbd[3+k] = sx_wbd[k];
        m_addr[3+k] = sx_waddr[k]; m_data[3+k] = sx_wdata[k];
      end
    end
  endtask

  task automatic lookup(input logic [3:0] a, output logic [63:0] v, output bit fwd);
    fwd = 1'b0;
    v = ref_mem[a];
    for (int p = 0; p < 5; p++) begin
      if (!fwd && m_en[p] && m_addr[p] == a) begin
        fwd = 1'b1;
        v = m_data[p];
      end
    end
  endtask

  task automatic cycle(input string ovr);
    logic [63:0] v;
    bit          fwd;
    int          coll;
    string       t;
    #1;
    build_writes();
    for (int i = 0; i < 6; i++) begin
      lookup(fix_raddr[i], v, fwd);
      t = (ovr != "") ? ovr : (fwd ? "R4" : "R3");
      check(t, fix_rdata[i], v);
    end
    for (int k = 0; k < 2; k++) begin
      lookup(perm_req ? perm_raddr[k] : sx_raddr[k], v, fwd);
      check((ovr != "") ? ovr : "R8", sh_rdata[k], v);
    end
    coll = 0;
    for (int p = 0; p < 5; p++)
      for (int q = p + 1; q < 5; q++)
        if (m_en[p] && m_en[q] && m_addr[p] == m_addr[q]) coll = 1;
    check((ovr != "") ? ovr : "R6", 64'(wr_collide), 64'(coll));
    check((ovr != "") ? ovr : "R7",
          {61'd0, share_conflict, perm_gnt, sx_gnt},
          {61'd0, perm_req && sx_req, perm_req, sx_req && !perm_req});
    @(posedge clk);
    if (rst_ni) begin
      for (int r = 0; r < 16; r++) begin
        bit seen = 1'b0;
        for (int p = 0; p < 5; p++) begin
          if (!seen && m_en[p] && m_addr[p] == 4'(r)) begin
            seen = 1'b1;
            if (!m_wbd[p]) ref_mem[r] = m_data[p];
          end
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    fix_raddr = '0; fix_we = '0; fix_wbd = '0; fix_waddr = '0; fix_wdata = '0;
    perm_req = 0; perm_raddr = '0; perm_we = '0; perm_wbd = '0; perm_waddr = '0; perm_wdata = '0;
    sx_req = 0; sx_raddr = '0; sx_we = '0; sx_wbd = '0; sx_waddr = '0; sx_wdata = '0;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    for (int r = 0; r < 16; r++) ref_mem[r] = '0;
    // dirty array before reset to see the clear
    rst_ni = 1'b1;
    @(negedge clk);
    fix_we = 3'b111; fix_waddr = {4'd9, 4'd3, 4'd1};
    fix_wdata = {64'hAAAA, 64'hBBBB, 64'hCCCC};
    @(negedge clk);
    idle();
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    // R1: all registers read zero after reset
    for (int g = 0; g < 3; g++) begin
      for (int i = 0; i < 6; i++) fix_raddr[i] = 4'((g * 6 + i) % 16);
      cycle("R1");
    end

    // R2: distinct registers on each fixed read port
    for (int r = 0; r < 3; r++) begin
      fix_we = 3'b111;
      fix_waddr = {4'(3*r+2), 4'(3*r+1), 4'(3*r)};
      fix_wdata = {rnd64(), rnd64(), rnd64()};
      cycle("R3");
    end
    idle();
    for (int i = 0; i < 6; i++) fix_raddr[i] = 4'(i + 1);
    cycle("R2");

    // R4: read sees same-cycle write
    fix_we[1] = 1'b1; fix_waddr[1] = 4'd12; fix_wdata[1] = 64'h1234_5678_9ABC_DEF0;
    fix_raddr[3] = 4'd12;
    cycle("R4");

    // R5: forward-only write forwards but does not store
    idle();
    fix_we[2] = 1'b1; fix_wbd[2] = 1'b1; fix_waddr[2] = 4'd4; fix_wdata[2] = 64'hDEAD_BEEF;
    fix_raddr[0] = 4'd4;
    cycle("R5");
    idle();
    fix_raddr[0] = 4'd4;
    cycle("R5");

    // R6: lowest port forward-only wins over a storing higher port
    fix_we = 3'b011; fix_wbd = 3'b001; fix_waddr = {4'd0, 4'd2, 4'd2};
    fix_wdata = {64'd0, 64'h2222, 64'h1111};
    fix_raddr[5] = 4'd2;
    cycle("R6");
    idle();
    fix_raddr[5] = 4'd2;
    cycle("R6");

    // R7 and R8: both request; scalar-exchange writes must be dropped
    perm_req = 1; sx_req = 1;
    perm_we = 2'b01; perm_waddr[0] = 4'd13; perm_wdata[0] = 64'h7777;
    sx_we = 2'b11; sx_waddr = {4'd14, 4'd15}; sx_wdata = {64'h5555, 64'h6666};
    perm_raddr = {4'd1, 4'd2}; sx_raddr = {4'd3, 4'd4};
    cycle("R7");
    idle();
    fix_raddr[0] = 4'd13; fix_raddr[1] = 4'd14; fix_raddr[2] = 4'd15;
    cycle("R8");

    // R9: second shared write port stores, via scalar-exchange grant
    sx_req = 1; sx_we = 2'b10; sx_waddr[1] = 4'd11; sx_wdata[1] = 64'h9999_0000_1111;
    sx_raddr = {4'd11, 4'd0};
    cycle("R9");
    idle();
    sx_raddr[1] = 4'd11;
    cycle("R9");

    // mixed traffic in a narrow address window
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < 6; i++) fix_raddr[i] = 4'($urandom_range(0, 5));
      fix_we = 3'($urandom); fix_wbd = 3'($urandom & $urandom);
      for (int p = 0; p < 3; p++) begin
        fix_waddr[p] = 4'($urandom_range(0, 5));
        fix_wdata[p] = rnd64();
      end
      perm_req = ($urandom_range(0, 2) == 0);
      sx_req = ($urandom_range(0, 1) == 0);
      perm_we = 2'($urandom); perm_wbd = 2'($urandom & $urandom);
      sx_we = 2'($urandom); sx_wbd = 2'($urandom & $urandom);
      for (int k = 0; k < 2; k++) begin
        perm_raddr[k] = 4'($urandom_range(0, 5)); sx_raddr[k] = 4'($urandom_range(0, 5));
        perm_waddr[k] = 4'($urandom_range(0, 5)); sx_waddr[k] = 4'($urandom_range(0, 5));
        perm_wdata[k] = rnd64(); sx_wdata[k] = rnd64();
      end
      cycle("");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule